// File: doc/BRIEF.md
# Six-Mode Programmable Counter Channel

This block is one 16-bit down-counting timer channel. It has a gate/trigger input, a single waveform output and an 8-bit byte port. The byte port loads the count and returns the live count. A control byte picks one of six behaviours. Two behaviours are one-time events: a level that rises at terminal count, and a strobe started by software. Two are started by an edge on the gate: a retriggerable low pulse and a retriggerable strobe. The last two run without end: a divide-by-N rate output and a square wave.

One 16-bit value is reached through the 8-bit port in one of two ways. Single-byte access moves only the low byte and clears the high byte. Double-byte access moves the low byte first and the high byte second. All timing runs on the system clock, one count per clock. The gate input passes through a two-stage synchronizer before any mode uses it. A rising edge on the synchronized level becomes a one-clock trigger.

Top module: `prog_counter_channel`

## Requirements
- R1: A control-byte write selects the mode from bits [2:0] and the access format from bit 3. Codes 0 to 5 select modes 0 to 5, code 6 acts as mode 2 and code 7 acts as mode 3. Bit 3 set means double-byte access and clear means single-byte access. Starting from the clock after the control write, the output is low in mode 0 and high in all other modes. After reset the output is high and the count reads 0.
- R2: In double-byte access the first data write supplies bits [7:0] and the second supplies bits [15:8]. In single-byte access one write supplies bits [7:0] and bits [15:8] become 0. A control write restarts the byte sequence at the low byte, so an unfinished pair is discarded.
- R3: `data_out` always shows a byte of the live count. In double-byte access it shows the low byte first, and each `data_rd` pulse alternates it between the low and the high byte. In single-byte access it always shows the low byte. A control write returns it to the low byte.
- R4: Mode 0: the count is loaded on the clock after the final byte is written, and the output is low from that write. The count goes down only while the synchronized gate is high, and the output goes high in the cycle the count reaches 0. It stays high until a new count is written.
- R5: Mode 1: the count is loaded and the output goes low 3 clocks after the gate input rises. The output returns high N clocks later. A new rising edge before then reloads N and lengthens the low pulse.
- R6: Mode 2 with N of at least 2: the output is low for 1 clock in every N clocks. The first low clock comes N clocks after the final byte write. A low gate freezes the count and holds the output high.
- R7: Mode 3 with N of at least 2: the count steps down by 2. The output is high for (N+1)/2 clocks and low for N/2 clocks, using integer division.
- R8: Mode 4: with the gate high, the output goes low for exactly one clock, N+1 clocks after the final byte write. No further strobe follows until the count is written again.
- R9: Mode 5: the output goes low for exactly one clock, N+3 clocks after the most recent rising edge of the gate input. A newer edge restarts the full count.
- R10: A written count of 0 counts 65536 clocks.
- R11: In modes 2 and 3, a count written while the channel runs leaves the current cycle unchanged and is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-byte write strobe |
| ctl_byte | input | 8 | Control byte: mode [2:0], access [3] |
| data_wr | input | 1 | Count byte write strobe |
| data_in | input | 8 | Count byte being written |
| data_rd | input | 1 | Readback byte advance strobe |
| data_out | output | 8 | Selected byte of the live count |
| gate_in | input | 1 | Asynchronous gate/trigger input |
| cnt_out | output | 1 | Channel output waveform |

## Verification
The bench builds the channel with its defaults: an 8-bit byte port, which gives a 16-bit count, and two synchronizer stages. With a 16-bit count, the 65536-clock case for a written 0 takes only one long wait. With two stages, the trigger-to-output delay is a fixed 3 clocks, so the one-shot and hardware-strobe timings can be checked to the exact clock. Random counts of 2 to 41 in the two periodic modes exercise both odd and even square-wave halves. Directed cases cover retriggering, reloading the count mid-run, pausing the gate and aborting a byte pair.

// File: rtl/pcc_pkg.sv
// Package: shared mode encoding and control-byte field positions for the
// programmable counter channel. Assumes a control byte of at least 4 bits.
package pcc_pkg;

    typedef enum logic [2:0] {
        M_TCOUNT   = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pcc_mode_e;

    localparam int MODE_LSB   = 0;
    localparam int ACCESS_BIT = 3;

    // Map the 3-bit mode field; the two spare codes alias the periodic modes.
    function automatic pcc_mode_e decode_mode(input logic [2:0] field);
        case (field)
            3'd0:    return M_TCOUNT;
            3'd1:    return M_ONESHOT;
            3'd2:    return M_RATE;
            3'd3:    return M_SQUARE;
            3'd4:    return M_SWSTROBE;
            3'd5:    return M_HWSTROBE;
            3'd6:    return M_RATE;
            default: return M_SQUARE;
        endcase
    endfunction

endpackage

// File: rtl/pcc_gate_sync.sv
// Gate synchronizer: brings the asynchronous gate into the clock domain
// through SYNC_STAGES flops and flags a rising edge of the synchronized
// level as a one-cycle pulse. Assumes SYNC_STAGES >= 1.
module pcc_gate_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_async,
    output logic gate_lvl,
    output logic gate_rise
);
    logic [SYNC_STAGES:0] shreg;

    // Shift the gate through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYNC_STAGES-1:0], gate_async};
    end

    assign gate_lvl  = shreg[SYNC_STAGES-1];
    assign gate_rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

endmodule

// File: rtl/pcc_byte_port.sv
// Byte port: assembles a count from one or two byte writes (low byte first)
// and presents the live count one byte at a time for readback.
// Assumes CNT_W == 2*BUS_W; a control write restarts both byte pointers.
module pcc_byte_port #(
    parameter int BUS_W = 8,
    parameter int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_dbl,
    input  logic             data_wr,
    input  logic [BUS_W-1:0] data_in,
    input  logic             data_rd,
    input  logic [CNT_W-1:0] count_q,
    output logic             wr_done,
    output logic [CNT_W-1:0] wr_value,
    output logic [BUS_W-1:0] data_out,
    output logic             wr_ptr
);
    localparam int HI_W = CNT_W - BUS_W;

    logic             dbl_q;
    logic             rd_ptr;
    logic [BUS_W-1:0] lsb_hold;

    // Track access format, byte pointers and the held low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_q    <= 1'b0;
            wr_ptr   <= 1'b0;
            rd_ptr   <= 1'b0;
            lsb_hold <= '0;
        end else if (ctl_wr) begin
            dbl_q  <= ctl_dbl;
            wr_ptr <= 1'b0;
            rd_ptr <= 1'b0;
        end else begin
            if (data_wr && dbl_q) begin
                wr_ptr <= ~wr_ptr;
                if (!wr_ptr) lsb_hold <= data_in;
            end
            if (data_rd && dbl_q) rd_ptr <= ~rd_ptr;
        end
    end

    // Flag a completed count and form its value.
    always_comb begin
        wr_done  = data_wr && !ctl_wr && (!dbl_q || wr_ptr);
        wr_value = dbl_q ? {data_in[HI_W-1:0], lsb_hold} : {{HI_W{1'b0}}, data_in};
    end

    // Select the readback byte of the live count.
    assign data_out = rd_ptr ? count_q[CNT_W-1:BUS_W] : count_q[BUS_W-1:0];

endmodule

// File: rtl/pcc_count_core.sv
// Counter core: the shared down-counter, reload register and per-mode
// output generation. One count per clock; square mode steps by two.
// Assumes wr_done/wr_value from the byte port and a synchronized gate.
module pcc_count_core
    import pcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  pcc_mode_e        ctl_mode,
    input  logic             wr_done,
    input  logic [CNT_W-1:0] wr_value,
    input  logic             gate_lvl,
    input  logic             gate_rise,
    output logic [CNT_W-1:0] count_q,
    output logic             out_q,
    output pcc_mode_e        mode_q,
    output logic             running_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] reload_q, reload_n, cnt_n, hi_load, lo_load;
    logic             have_q, have_n, pend_q, pend_n, run_n, out_n;
    pcc_mode_e        mode_n;
    logic             trig_mode, periodic, strobe_mode, start, dec_en;

    // Classify the mode and decide whether to load or count this cycle.
    always_comb begin
        trig_mode   = (mode_q == M_ONESHOT) || (mode_q == M_HWSTROBE);
        periodic    = (mode_q == M_RATE) || (mode_q == M_SQUARE);
        strobe_mode = (mode_q == M_SWSTROBE) || (mode_q == M_HWSTROBE);
        start       = pend_q || (trig_mode && gate_rise && have_q);
        dec_en      = running_q && (trig_mode || gate_lvl) && !start;
        hi_load     = reload_q + {{(CNT_W-1){1'b0}}, reload_q[0]};
        lo_load     = reload_q - {{(CNT_W-1){1'b0}}, reload_q[0]};
    end

    // Next-state logic for the counter, output and bookkeeping flags.
    always_comb begin
        mode_n   = mode_q;
        reload_n = reload_q;
        have_n   = have_q;
        pend_n   = pend_q;
        run_n    = running_q;
        cnt_n    = count_q;
        out_n    = out_q;
        if (ctl_wr) begin
            mode_n = ctl_mode;
            have_n = 1'b0;
            pend_n = 1'b0;
            run_n  = 1'b0;
            out_n  = (ctl_mode != M_TCOUNT);
        end else begin
            if (start) begin
                pend_n = 1'b0;
                run_n  = 1'b1;
                cnt_n  = (mode_q == M_SQUARE) ? hi_load : reload_q;
                if (mode_q == M_ONESHOT)     out_n = 1'b0;
                else if (mode_q != M_TCOUNT) out_n = 1'b1;
            end else if (dec_en) begin
                unique case (mode_q)
                    M_TCOUNT, M_ONESHOT: begin
                        cnt_n = count_q - ONE;
                        if (count_q == ONE) begin
                            out_n = 1'b1;
                            run_n = 1'b0;
                        end
                    end
                    M_SWSTROBE, M_HWSTROBE: begin
                        cnt_n = count_q - ONE;
                        out_n = 1'b1;
                        if (count_q == ONE) begin
                            out_n = 1'b0;
                            run_n = 1'b0;
                        end
                    end
                    M_RATE: begin
                        if (count_q == ONE) begin
                            cnt_n = reload_q;
                            out_n = 1'b1;
                        end else begin
                            cnt_n = count_q - ONE;
                            out_n = (count_q != TWO);
                        end
                    end
                    M_SQUARE: begin
                        if (count_q == TWO) begin
                            out_n = ~out_q;
                            cnt_n = out_q ? lo_load : hi_load;
                        end else begin
                            cnt_n = count_q - TWO;
                        end
                    end
                    default: ;
                endcase
            end else begin
                if (strobe_mode)             out_n = 1'b1;
                if (periodic && !gate_lvl)   out_n = 1'b1;
            end
            if (wr_done) begin
                reload_n = wr_value;
                have_n   = 1'b1;
                if (!trig_mode && !(periodic && running_q)) pend_n = 1'b1;
                if (mode_q == M_TCOUNT) out_n = 1'b0;
            end
        end
    end

    // Register the channel state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_SWSTROBE;
            reload_q  <= '0;
            have_q    <= 1'b0;
            pend_q    <= 1'b0;
            running_q <= 1'b0;
            count_q   <= '0;
            out_q     <= 1'b1;
        end else begin
            mode_q    <= mode_n;
            reload_q  <= reload_n;
            have_q    <= have_n;
            pend_q    <= pend_n;
            running_q <= run_n;
            count_q   <= cnt_n;
            out_q     <= out_n;
        end
    end

endmodule

// File: rtl/prog_counter_channel.sv
// Top: one programmable counter channel. Wires the gate synchronizer, the
// byte port and the counter core. Control byte: mode in [2:0], double-byte
// access in [3]. Assumes BUS_W >= 4 so the control fields fit.
module prog_counter_channel
    import pcc_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [BUS_W-1:0] ctl_byte,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [BUS_W-1:0] data_in,
    output logic [BUS_W-1:0] data_out,
    input  logic             gate_in,
    output logic             cnt_out
);
    localparam int CNT_W = 2 * BUS_W;

    logic             gate_lvl, gate_rise, wr_done, wr_ptr, core_running;
    logic [CNT_W-1:0] wr_value, core_count;
    pcc_mode_e        core_mode, ctl_mode;

    assign ctl_mode = decode_mode(ctl_byte[MODE_LSB +: 3]);

    pcc_gate_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_async (gate_in),
        .gate_lvl   (gate_lvl),
        .gate_rise  (gate_rise)
    );

    pcc_byte_port #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_dbl  (ctl_byte[ACCESS_BIT]),
        .data_wr  (data_wr),
        .data_in  (data_in),
        .data_rd  (data_rd),
        .count_q  (core_count),
        .wr_done  (wr_done),
        .wr_value (wr_value),
        .data_out (data_out),
        .wr_ptr   (wr_ptr)
    );

    pcc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_mode  (ctl_mode),
        .wr_done   (wr_done),
        .wr_value  (wr_value),
        .gate_lvl  (gate_lvl),
        .gate_rise (gate_rise),
        .count_q   (core_count),
        .out_q     (cnt_out),
        .mode_q    (core_mode),
        .running_q (core_running)
    );

endmodule

// File: rtl/pcc_checker.sv
// Checker: temporal properties of the counter channel, bound to the top.
module pcc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             cnt_out,
    input logic [2:0]       mode_q,
    input logic             gate_lvl,
    input logic             wr_ptr,
    input logic [CNT_W-1:0] count_q,
    input logic             running_q
);
    logic strobe_set, periodic;
    assign strobe_set = (mode_q == 3'd2) || (mode_q == 3'd4) || (mode_q == 3'd5);
    assign periodic   = (mode_q == 3'd2) || (mode_q == 3'd3);

    // R8 (also R6, R9): strobe-type low pulses last one clock.
    assert_strobe_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_set && $fell(cnt_out) && !ctl_wr) |=> cnt_out);

    assert_ptr_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !wr_ptr);

    assert_gate_low_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic && !gate_lvl && !ctl_wr) |=> cnt_out);

    // R4 (also R5): in modes 0 and 1 the output only rises at terminal count.
    assert_rise_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'd0 || mode_q == 3'd1) && $rose(cnt_out) && !$past(ctl_wr))
            |-> (count_q == '0));

    assert_square_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd3 && running_q) |-> !count_q[0]);

endmodule

bind prog_counter_channel pcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .cnt_out   (cnt_out),
    .mode_q    (core_mode),
    .gate_lvl  (gate_lvl),
    .wr_ptr    (wr_ptr),
    .count_q   (core_count),
    .running_q (core_running)
);

// File: tb/sim_prog_counter_channel.sv
`timescale 1ns/100ps
module sim_prog_counter_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0, gate_in = 1'b0;
    logic [7:0] ctl_byte = '0, data_in = '0;
    logic [7:0] data_out;
    logic       cnt_out;
    int         checks = 0, fails = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    prog_counter_channel u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
        .data_wr(data_wr), .data_rd(data_rd), .data_in(data_in),
        .data_out(data_out), .gate_in(gate_in), .cnt_out(cnt_out)
    );

    function automatic int sq_high(input int n); return (n + 1) / 2; endfunction
    function automatic int sq_low(input int n);  return n / 2;       endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step; @(negedge clk); endtask
    task automatic wctl(input logic [7:0] b);
        ctl_byte = b; ctl_wr = 1'b1; step; ctl_wr = 1'b0;
    endtask
    task automatic wbyte(input logic [7:0] b);
        data_in = b; data_wr = 1'b1; step; data_wr = 1'b0;
    endtask
    task automatic load(input int n, input bit dbl);
        wbyte(n[7:0]);
        if (dbl) wbyte(n[15:8]);
    endtask
    task automatic rd_pulse; data_rd = 1'b1; step; data_rd = 1'b0; endtask
    task automatic set_gate(input logic v); gate_in = v; repeat (4) step; endtask

    task automatic measure(input int win, output int ffall, output int lowl, output int highl);
        int   ph = 0, t0 = 0;
        logic prev;
        ffall = -1; lowl = -1; highl = -1;
        prev = cnt_out;
        for (int i = 1; i <= win; i++) begin
            step;
            if (prev && !cnt_out) begin
                if (ph == 0) begin ffall = i; t0 = i; ph = 1; end
                else if (ph == 2) begin highl = i - t0; ph = 3; end
            end
            if (!prev && cnt_out && ph == 1) begin lowl = i - t0; t0 = i; ph = 2; end
            prev = cnt_out;
        end
    endtask

    initial begin
        int n, ff, lw, hg, m;
        bit ok;
        void'($urandom(32'h5EED));
        repeat (4) step;
        rst_n = 1'b1;
        step;
        chk(cnt_out == 1'b1, "R1 reset output", cnt_out, 1);
        chk(data_out == 8'h00, "R1 reset count", data_out, 0);

        // R1: initial output level after control writes
        wctl(8'h00); chk(cnt_out == 1'b0, "R1 mode0 level", cnt_out, 0);
        wctl(8'h04); chk(cnt_out == 1'b1, "R1 mode4 level", cnt_out, 1);

        // R2/R3: double-byte load and readback, gate low so count holds
        set_gate(1'b0);
        wctl(8'h08); wbyte(8'h34); wbyte(8'h12); step;
        chk(data_out == 8'h34, "R3 low byte", data_out, 8'h34);
        rd_pulse; chk(data_out == 8'h12, "R2 high byte", data_out, 8'h12);
        rd_pulse; chk(data_out == 8'h34, "R3 back to low", data_out, 8'h34);
        repeat (8) step;
        chk(data_out == 8'h34 && cnt_out == 1'b0, "R4 gate low holds", data_out, 8'h34);
        // R2: an unfinished byte pair is discarded by a control write
        wctl(8'h08); wbyte(8'hAA); wctl(8'h08); load(16'h0456, 1'b1); step;
        chk(data_out == 8'h56, "R2 restart low", data_out, 8'h56);
        rd_pulse; chk(data_out == 8'h04, "R2 restart high", data_out, 8'h04);
        // R3: live count while counting in mode 0
        wctl(8'h08); load(16'h0300, 1'b1); step;
        gate_in = 1'b1; repeat (10) step;
        chk(data_out == 8'hF8, "R3 live low", data_out, 8'hF8);
        rd_pulse; chk(data_out == 8'h02, "R3 live high", data_out, 8'h02);
        // R3: single-byte readback stays on the low byte
        wctl(8'h00); wbyte(8'h7E); gate_in = 1'b0; step;
        rd_pulse; chk(data_out == 8'h7E || data_out == 8'h7D || data_out == 8'h7C,
                      "R3 single low", data_out, 8'h7E);

        // R4/R2: mode 0 terminal with single-byte 5 (high byte zero)
        set_gate(1'b0); wctl(8'h00); load(5, 1'b0); step;
        gate_in = 1'b1; repeat (6) step;
        chk(cnt_out == 1'b0, "R4 low before zero", cnt_out, 0);
        step; chk(cnt_out == 1'b1, "R4 high at zero R2", cnt_out, 1);
        repeat (5) step; chk(cnt_out == 1'b1, "R4 stays high", cnt_out, 1);

        // R5: one-shot low for N, then retriggered pulse of N+4
        set_gate(1'b0); wctl(8'h01); load(9, 1'b0);
        gate_in = 1'b1; repeat (2) step;
        chk(cnt_out == 1'b1, "R5 before trigger", cnt_out, 1);
        step; chk(cnt_out == 1'b0, "R5 pulse start", cnt_out, 0);
        repeat (8) step; chk(cnt_out == 1'b0, "R5 still low", cnt_out, 0);
        step; chk(cnt_out == 1'b1, "R5 pulse end", cnt_out, 1);
        set_gate(1'b0);
        gate_in = 1'b1; repeat (2) step; gate_in = 1'b0; repeat (2) step; gate_in = 1'b1;
        repeat (11) step; chk(cnt_out == 1'b0, "R5 retrigger low", cnt_out, 0);
        step; chk(cnt_out == 1'b1, "R5 retrigger end", cnt_out, 1);

        // R6: rate generator directed
        set_gate(1'b1); wctl(8'h02); load(7, 1'b0);
        measure(40, ff, lw, hg);
        chk(ff == 7, "R6 first strobe", ff, 7);
        chk(lw == 1 && hg == 6, "R6 low width", lw, 1);
        // R6: gate low holds output high
        gate_in = 1'b0; ok = 1'b1;
        repeat (3) step;
        repeat (20) begin step; if (cnt_out !== 1'b1) ok = 1'b0; end
        chk(ok, "R6 gate low high", cnt_out, 1);

        // R11: count rewritten mid-run takes effect at the next reload
        set_gate(1'b1); wctl(8'h02); load(10, 1'b0);
        repeat (3) step; wbyte(8'd6);
        ff = -1; lw = -1;
        for (int s = 5; s <= 30; s++) begin
            step;
            if (!cnt_out && ff < 0) ff = s;
            else if (!cnt_out && lw < 0) lw = s;
        end
        chk(ff == 10, "R11 old schedule", ff, 10);
        chk(lw == 16, "R11 new period", lw, 16);

        // R7/R1: square wave via alias code 7, N = 6
        wctl(8'h07); load(6, 1'b0);
        measure(40, ff, lw, hg);
        chk(lw == 3 && hg == 3, "R7 R1 alias even", lw * 100 + hg, 303);

        // R6/R7: random periodic runs
        for (int it = 0; it < 8; it++) begin
            m = ($urandom % 2) ? 2 : 3;
            n = 2 + int'($urandom % 40);
            wctl(8'(m)); load(n, 1'b0);
            measure(3 * n + 10, ff, lw, hg);
            if (m == 2) chk(ff == n && lw == 1 && hg == n - 1, "R6 random", ff, n);
            else        chk(lw == sq_low(n) && hg == sq_high(n), "R7 random",
                            lw * 1000 + hg, sq_low(n) * 1000 + sq_high(n));
        end

        // R8: random software strobes, no repeat
        for (int it = 0; it < 4; it++) begin
            n = 2 + int'($urandom % 50);
            wctl(8'h04); load(n, 1'b0);
            repeat (n) step; chk(cnt_out == 1'b1, "R8 before strobe", cnt_out, 1);
            step; chk(cnt_out == 1'b0, "R8 strobe", cnt_out, 0);
            ok = 1'b1;
            repeat (2 * n) begin step; if (cnt_out !== 1'b1) ok = 1'b0; end
            chk(ok, "R8 no repeat", cnt_out, 1);
        end

        // R9: hardware strobe, plain and retriggered, N = 12
        set_gate(1'b0); wctl(8'h05); load(12, 1'b0);
        gate_in = 1'b1; repeat (14) step;
        chk(cnt_out == 1'b1, "R9 before strobe", cnt_out, 1);
        step; chk(cnt_out == 1'b0, "R9 strobe", cnt_out, 0);
        step; chk(cnt_out == 1'b1, "R9 strobe one clock", cnt_out, 1);
        set_gate(1'b0);
        gate_in = 1'b1; repeat (2) step; gate_in = 1'b0; repeat (2) step; gate_in = 1'b1;
        ok = 1'b1;
        repeat (14) begin step; if (cnt_out !== 1'b1) ok = 1'b0; end
        chk(ok, "R9 retrigger delays", cnt_out, 1);
        step; chk(cnt_out == 1'b0, "R9 retrigger strobe", cnt_out, 0);

        // R10: zero count is 65536 clocks
        set_gate(1'b1); wctl(8'h04); load(0, 1'b0);
        repeat (65536) step; chk(cnt_out == 1'b1, "R10 before end", cnt_out, 1);
        step; chk(cnt_out == 1'b0, "R10 strobe", cnt_out, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule